// File: doc/BRIEF.md
# Pin Interrupt Trigger Unit

This block watches four general-purpose pins that double as external interrupt sources. It raises one interrupt request per channel toward a downstream interrupt controller. Each channel has a four-bit slice of a single control word. The low three bits of the slice select the trigger condition and the top bit enables the channel. Every pin passes through a two-flop synchroniser before it is tested.

In the level conditions, the request follows the synchronised pin directly. In the edge conditions, a detected edge parks the channel in a pending state. The channel stays there until software writes a one to the matching bit of the clear port. The control word also holds two timer pin-function enables. The block stores these and returns them, but does not act on them.

Each channel is a small state machine with four states:
- `CH_OFF`: channel disabled or an unused code selected.
- `CH_LEVEL`: a level code is selected.
- `CH_ARMED`: an edge code is selected and no edge has been seen.
- `CH_PEND`: an edge has been latched.

The transitions are:
- Any state goes to `CH_OFF` when the class becomes off.
- Any state goes to `CH_LEVEL` when the class becomes level.
- `CH_OFF`, `CH_LEVEL` and `CH_ARMED` go to `CH_PEND` on a matching edge.
- `CH_OFF` and `CH_LEVEL` go to `CH_ARMED` in an edge class with no matching edge.
- `CH_PEND` goes to `CH_ARMED` on a clear with no matching edge.
- `CH_PEND` stays in `CH_PEND` otherwise.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, the control word reads 0 and all requests are low.
- R2: The control word layout is fixed. Channel n takes its trigger code from bits [4n+2:4n] and its enable from bit 4n+3. Bits 16 and 17 are timer pin-function enables that are stored and read back on `cfg_q` and have no effect on any request. The word is loaded only when `cfg_we` is high.
- R3: With code 0 (active-low level) enabled, the request equals the inverted pin. A pin change driven between edges shows on the request after the second following clock edge, and not after the first.
- R4: With code 1 (active-high level) enabled, the request equals the pin, with the same two-edge latency.
- R5: With code 2 (rising edge) enabled, a rising pin sets the request after the third following clock edge. The request stays set after the pin falls.
- R6: With code 4 (falling edge) enabled, a falling pin sets a sticky request. A rising pin does not set it.
- R7: With code 6 (both edges) enabled, either pin transition sets a sticky request.
- R8: A clock edge with `clr_we` high and bit n of `clr_mask` set drops a pending request on channel n. Channels whose mask bit is 0 keep their pending requests.
- R9: A matching edge detected in the same cycle as a clear of that channel leaves the request set.
- R10: Codes 3, 5 and 7 never raise a request. A channel whose enable bit is 0 never raises a request, for any code and pin activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the control word |
| cfg_wdata | input | 18 | New control word |
| clr_we | input | 1 | Apply the clear mask |
| clr_mask | input | 4 | One bit per channel; 1 drops that channel's pending edge |
| pin_in | input | 4 | Asynchronous pin inputs |
| cfg_q | output | 18 | Current control word |
| irq_req | output | 4 | Interrupt request per channel |

## Verification
The hardest case to reach from the ports is a clear that lands in exactly the cycle in which a new edge is recognised. Recognition happens only after the pin has crossed both synchroniser flops, so the bench counts those edges precisely. It moves the pin half a cycle before one edge and raises the clear for the third edge after it. It then repeats the sequence with no edge, to show that the clear alone does drop the request. A full sweep over every channel, all eight codes and both enable values also samples the request one edge too early. This pins down the synchroniser latency for the level and edge classes.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Trigger code layout within one channel slice
    localparam int MODE_W  = 3;
    localparam int SLICE_W = MODE_W + 1;

    localparam logic [MODE_W-1:0] TRIG_LOW  = 3'd0;
    localparam logic [MODE_W-1:0] TRIG_HIGH = 3'd1;
    localparam logic [MODE_W-1:0] TRIG_RISE = 3'd2;
    localparam logic [MODE_W-1:0] TRIG_FALL = 3'd4;
    localparam logic [MODE_W-1:0] TRIG_BOTH = 3'd6;

    typedef enum logic [1:0] {
        CLS_OFF,
        CLS_LEVEL,
        CLS_EDGE
    } trig_class_e;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_LEVEL,
        CH_ARMED,
        CH_PEND
    } ch_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[b] <= '0;
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], d_async[b]};
            end
        end
        assign q_sync[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
    import pin_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MODE_W-1:0] mode,
    input  logic              pin_s,
    input  logic              clr,
    output logic              irq
);

    ch_state_e   st_q;
    ch_state_e   st_d;
    trig_class_e cls;
    logic        prev_q;
    logic        hit;
    logic        lvl_match;

    // Previous synchronised level, for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    // Classify the selected trigger code
    always_comb begin
        cls = CLS_OFF;
        if (enable) begin
            case (mode)
                TRIG_LOW, TRIG_HIGH:            cls = CLS_LEVEL;
                TRIG_RISE, TRIG_FALL, TRIG_BOTH: cls = CLS_EDGE;
                default:                        cls = CLS_OFF;
            endcase
        end
    end

    always_comb begin
        case (mode)
            TRIG_RISE: hit = pin_s & ~prev_q;
            TRIG_FALL: hit = ~pin_s & prev_q;
            TRIG_BOTH: hit = pin_s ^ prev_q;
            default:   hit = 1'b0;
        endcase
    end

    assign lvl_match = (mode == TRIG_HIGH) ? pin_s : ~pin_s;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (cls)
            CLS_OFF:   st_d = CH_OFF;
            CLS_LEVEL: st_d = CH_LEVEL;
            CLS_EDGE: begin
                unique case (st_q)
                    CH_OFF, CH_LEVEL, CH_ARMED: st_d = hit ? CH_PEND : CH_ARMED;
                    CH_PEND:                    st_d = (clr && !hit) ? CH_ARMED : CH_PEND;
                endcase
            end
            default:   st_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CH_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Output decode
    always_comb begin
        irq = 1'b0;
        unique case (st_q)
            CH_OFF:   irq = 1'b0;
            CH_LEVEL: irq = (cls == CLS_LEVEL) && lvl_match;
            CH_ARMED: irq = 1'b0;
            CH_PEND:  irq = (cls == CLS_EDGE);
        endcase
    end

    // R8
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PEND && cls == CLS_EDGE && clr && !hit) |=> (st_q == CH_ARMED));

    // R9
    clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PEND && cls == CLS_EDGE && clr && hit) |=> (st_q == CH_PEND));

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PEND && cls == CLS_EDGE && !clr) |=> (st_q == CH_PEND));

    // R10
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_OFF) |=> (st_q == CH_OFF));

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NUM_TIMERS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [NUM_CH*SLICE_W+NUM_TIMERS-1:0] cfg_wdata,
    input  logic                                 clr_we,
    input  logic [NUM_CH-1:0]                    clr_mask,
    input  logic [NUM_CH-1:0]                    pin_in,
    output logic [NUM_CH*SLICE_W+NUM_TIMERS-1:0] cfg_q,
    output logic [NUM_CH-1:0]                    irq_req
);

    localparam int CFG_W = NUM_CH * SLICE_W + NUM_TIMERS;

    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] en_vec;

    pin_irq_cfg #(.WIDTH(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    pin_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign en_vec[c] = cfg_q[c*SLICE_W + MODE_W];

        pin_irq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (en_vec[c]),
            .mode   (cfg_q[c*SLICE_W +: MODE_W]),
            .pin_s  (pin_s[c]),
            .clr    (clr_we && clr_mask[c]),
            .irq    (irq_req[c])
        );
    end

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~en_vec) == '0);

endmodule

// File: tb/sim_pin_irq_unit.sv
`timescale 1ns/1ps
module sim_pin_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [17:0] cfg_wdata = '0;
    logic        clr_we = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic [3:0]  pin_in = '0;
    logic [17:0] cfg_q;
    logic [3:0]  irq_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_irq_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .clr_we    (clr_we),
        .clr_mask  (clr_mask),
        .pin_in    (pin_in),
        .cfg_q     (cfg_q),
        .irq_req   (irq_req)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [17:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [3:0] m);
        clr_mask = m; clr_we = 1'b1;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    function automatic logic [3:0] onbit(input int ch, input bit v);
        return v ? (4'b1 << ch) : 4'b0;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        // R1 reset state
        chk("R1", cfg_q, 18'h0);
        chk("R1", {14'h0, irq_req}, 18'h0);
        rst_n = 1'b1;
        wait_n(2);

        // Sweep over channel, code and enable (R3..R7, R10)
        for (int ch = 0; ch < 4; ch++) begin
            for (int md = 0; md < 8; md++) begin
                for (int en = 0; en < 2; en++) begin
                    bit on, lvl, edg;
                    on = (en == 1);
                    pin_in = '0;
                    write_cfg(18'((en * 8 + md) << (4 * ch)));
                    wait_n(3);
                    clear(4'hF);
                    wait_n(1);
                    lvl = on && (md == 0 || md == 1);
                    edg = on && (md == 2 || md == 4 || md == 6);
                    // pin low, settled
                    chk(on && md == 0 ? "R3" : "R10", irq_req, onbit(ch, on && md == 0));
                    pin_in[ch] = 1'b1;
                    wait_n(1);
                    chk("R3 latency", irq_req, onbit(ch, on && md == 0));
                    wait_n(1);
                    chk("R4", irq_req, onbit(ch, on && md == 1));
                    wait_n(1);
                    chk("R5 R7", irq_req, onbit(ch, (on && md == 1) || (on && (md == 2 || md == 6))));
                    pin_in[ch] = 1'b0;
                    wait_n(3);
                    chk("R6 R5 sticky", irq_req, onbit(ch, (on && md == 0) || edg));
                    clear(onbit(ch, 1'b1));
                    chk("R8", irq_req, onbit(ch, on && md == 0));
                    if (!lvl && !edg) chk("R10", irq_req, 4'h0);
                end
            end
        end

        // R2 timer bits stored, no effect on requests
        pin_in = '0;
        write_cfg(18'h30000);
        chk("R2", cfg_q, 18'h30000);
        pin_in = 4'hF; wait_n(4);
        chk("R2", {14'h0, irq_req}, 18'h0);
        pin_in = 4'h0; wait_n(4);
        chk("R2", {14'h0, irq_req}, 18'h0);
        // R2 no load without cfg_we
        cfg_wdata = 18'h2AAAA;
        wait_n(2);
        chk("R2", cfg_q, 18'h30000);

        // Mixed channels: ch0 low, ch1 high, ch2 rise, ch3 fall (R2)
        write_cfg(18'hCA98);
        chk("R2", cfg_q, 18'h0CA98);
        wait_n(3);
        clear(4'hF);
        chk("R2 R3", irq_req, 4'b0001);
        pin_in = 4'hF; wait_n(3);
        chk("R2 R4 R5", irq_req, 4'b0110);
        pin_in = 4'h0; wait_n(3);
        chk("R2 R6", irq_req, 4'b1101);

        // R8 clear independence: ch0 and ch1 rising, both pending
        write_cfg(18'h000AA);
        wait_n(3);
        clear(4'hF);
        pin_in = 4'b0011; wait_n(3);
        chk("R8", irq_req, 4'b0011);
        clear(4'b0010);
        chk("R8", irq_req, 4'b0001);
        clear(4'b0000);
        chk("R8", irq_req, 4'b0001);

        // R9 clear meets new edge: ch0 both edges
        pin_in = 4'b0000;
        write_cfg(18'h0000E);
        wait_n(4);
        clear(4'hF);
        pin_in[0] = 1'b1; wait_n(3);
        chk("R9", irq_req, 4'b0001);
        pin_in[0] = 1'b0;
        wait_n(2);
        clr_mask = 4'b0001; clr_we = 1'b1;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
        chk("R9", irq_req, 4'b0001);
        wait_n(2);
        clear(4'b0001);
        chk("R9 R8", irq_req, 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule